// File: doc/BRIEF.md
# Magic-Word Sequence Access Unlocker

This block watches writes to a single 32-bit access-control register and opens a protected information-memory window only after three fixed magic words have been written there in the exact order. The first word is 0x3A7F5CA3, the second 0xA1E34F20 and the third 0x9608B2C1. Every other write drops access at once. This includes the conventional lock word 0xDEADBEEF and any value such as 0x1234 that software writes to force a known starting state.

In parallel, the block checks each memory access request against the protected window. The window starts at a base address and ends just below base plus twice the block size. Accesses outside the window pass through untouched. Accesses inside it are granted only while the block is unlocked. While the block is locked, such an access is refused and raises an access-violation pulse in the same cycle. The memory behind the window is not part of this block.

Top module: `magicSeqUnlocker`

## Requirements
- R1: After reset `unlocked` is 0 and the sequence tracker is idle, so only a full three-word sequence can open access.
- R2: Writing (with `keyWrEn` high) 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 sets `unlocked` to 1 on the clock edge that captures the third write. After only the first one or two words, `unlocked` stays 0.
- R3: Any key write while unlocked clears `unlocked` on the edge that captures it. This holds for the lock word 0xDEADBEEF and for any other value such as 0x1234.
- R4: A write in the middle of the sequence that is not the expected next word returns the tracker to idle. The words already accepted are discarded.
- R5: A wrong mid-sequence word equal to the first magic word 0x3A7F5CA3 counts as step one, so 0x3A7F5CA3, 0x3A7F5CA3, 0xA1E34F20, 0x9608B2C1 unlocks.
- R6: Cycles with `keyWrEn` low change neither `unlocked` nor the tracker, whatever `keyWrData` holds.
- R7: An address is inside the protected window when REGION_BASE <= `accAddr` < REGION_BASE + 2*BLOCK_SIZE. Both edges are exact.
- R8: While locked, a valid access inside the window gives `accEnable`=0 and `accViolation`=1 in the same cycle. A valid access outside the window gives `accEnable`=1 and `accViolation`=0.
- R9: While unlocked, a valid access inside the window gives `accEnable`=1 and `accViolation`=0.
- R10: With `accValid` low, both `accEnable` and `accViolation` are 0.
- R11: Writing the first magic word while unlocked relocks and counts as step one, so the next two magic words unlock again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| keyWrEn | input | 1 | Write strobe for the access-control register |
| keyWrData | input | 32 | Data written to the access-control register |
| accValid | input | 1 | A memory access request is present |
| accAddr | input | ADDR_W | Address of the access request |
| unlocked | output | 1 | Protected window is open |
| accEnable | output | 1 | Access is allowed to proceed |
| accViolation | output | 1 | Access to the locked window was refused (one pulse per cycle of request) |

## Verification
A key write is captured on one rising edge, and `unlocked` carries the result from that edge onward. The bench therefore drives each write at a falling edge, releases the strobe at the next falling edge, and reads `unlocked` just after that second falling edge. `accEnable` and `accViolation` are combinational from `accValid`, `accAddr` and the current `unlocked`. Each probe sets these inputs away from the clock edge and samples after a short settling delay, with no rising edge in between. The checks cover each step of the sequence, the restart cases and the window edges one address either side of each bound.

// File: rtl/unlockPkg.sv
package unlockPkg;

  localparam int unsigned WORD_W = 32;

  // strobes from the sequence control to the datapath
  typedef struct packed {
    logic open;   // final magic word accepted
    logic close;  // any other captured write
  } seqStrobe_t;

endpackage

// File: rtl/unlockCtrl.sv
module unlockCtrl
  import unlockPkg::*;
#(
  parameter int unsigned NUM_KEYS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                keyWrEn,
  input  logic [NUM_KEYS-1:0] keyHit,
  output seqStrobe_t          strobe
);

  localparam int unsigned STEP_W = $clog2(NUM_KEYS + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_KEYS - 1);
  localparam logic [STEP_W-1:0] ONE_STEP  = STEP_W'(1);

  logic [STEP_W-1:0] stepQ;
  logic [STEP_W-1:0] stepNext;
  logic              expectHit;

  // match against the word expected at the current step only
  always_comb begin
    expectHit = 1'b0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (stepQ == STEP_W'(i)) expectHit = keyHit[i];
    end
  end

  always_comb begin
    stepNext = stepQ;
    strobe   = '0;
    if (keyWrEn) begin
      if (expectHit) begin
        stepNext = stepQ + ONE_STEP;
      end else begin
        stepNext = keyHit[0] ? ONE_STEP : '0;
      end
      strobe.open  = expectHit && (stepQ == LAST_STEP);
      strobe.close = !strobe.open;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stepQ <= '0;
    else       stepQ <= stepNext;
  end

endmodule

// File: rtl/unlockDatapath.sv
module unlockDatapath
  import unlockPkg::*;
#(
  parameter int unsigned                       ADDR_W      = 32,
  parameter int unsigned                       NUM_KEYS    = 3,
  parameter logic [NUM_KEYS-1:0][WORD_W-1:0]   KEY_SEQ     = '0,
  parameter logic [ADDR_W-1:0]                 REGION_BASE = '0,
  parameter logic [ADDR_W-1:0]                 BLOCK_SIZE  = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WORD_W-1:0]   keyWrData,
  input  logic                accValid,
  input  logic [ADDR_W-1:0]   accAddr,
  input  seqStrobe_t          strobe,
  output logic [NUM_KEYS-1:0] keyHit,
  output logic                unlocked,
  output logic                accEnable,
  output logic                accViolation
);

  // two spare bits keep base + 2*size from wrapping
  localparam int unsigned EXT_W = ADDR_W + 2;
  localparam logic [EXT_W-1:0] LO_EXT = EXT_W'(REGION_BASE);
  localparam logic [EXT_W-1:0] HI_EXT = EXT_W'(REGION_BASE) + (EXT_W'(BLOCK_SIZE) << 1);

  for (genvar g = 0; g < NUM_KEYS; g++) begin : gKeyCmp
    assign keyHit[g] = (keyWrData == KEY_SEQ[g]);
  end

  logic [EXT_W-1:0] addrExt;
  logic             inRegion;
  logic             openQ;

  assign addrExt  = EXT_W'(accAddr);
  assign inRegion = (addrExt >= LO_EXT) && (addrExt < HI_EXT);

  always_ff @(posedge clk) begin
    if (!rstN)             openQ <= 1'b0;
    else if (strobe.open)  openQ <= 1'b1;
    else if (strobe.close) openQ <= 1'b0;
  end

  assign unlocked     = openQ;
  assign accEnable    = accValid && (!inRegion || openQ);
  assign accViolation = accValid && inRegion && !openQ;

endmodule

// File: rtl/magicSeqUnlocker.sv
module magicSeqUnlocker
  import unlockPkg::*;
#(
  parameter int unsigned                     ADDR_W      = 32,
  parameter int unsigned                     NUM_KEYS    = 3,
  parameter logic [NUM_KEYS-1:0][WORD_W-1:0] KEY_SEQ     = {32'h9608B2C1, 32'hA1E34F20, 32'h3A7F5CA3},
  parameter logic [ADDR_W-1:0]               REGION_BASE = ADDR_W'(32'h0004_0000),
  parameter logic [ADDR_W-1:0]               BLOCK_SIZE  = ADDR_W'(32'h0000_2000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyWrEn,
  input  logic [31:0]       keyWrData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              unlocked,
  output logic              accEnable,
  output logic              accViolation
);

  seqStrobe_t          strobe;
  logic [NUM_KEYS-1:0] keyHit;

  unlockCtrl #(.NUM_KEYS(NUM_KEYS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .keyWrEn (keyWrEn),
    .keyHit  (keyHit),
    .strobe  (strobe)
  );

  unlockDatapath #(
    .ADDR_W      (ADDR_W),
    .NUM_KEYS    (NUM_KEYS),
    .KEY_SEQ     (KEY_SEQ),
    .REGION_BASE (REGION_BASE),
    .BLOCK_SIZE  (BLOCK_SIZE)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .keyWrData    (keyWrData),
    .accValid     (accValid),
    .accAddr      (accAddr),
    .strobe       (strobe),
    .keyHit       (keyHit),
    .unlocked     (unlocked),
    .accEnable    (accEnable),
    .accViolation (accViolation)
  );

endmodule

// File: rtl/unlockChk.sv
module unlockChk #(
  parameter logic [31:0] LAST_KEY = 32'h0
) (
  input logic        clk,
  input logic        rstN,
  input logic        keyWrEn,
  input logic [31:0] keyWrData,
  input logic        accValid,
  input logic        unlocked,
  input logic        accEnable,
  input logic        accViolation
);

  // R2
  open_needs_last_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> ($past(keyWrEn) && ($past(keyWrData) == LAST_KEY)));

  // R3
  relock_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && keyWrEn) |=> !unlocked);

  // R6
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !keyWrEn |=> $stable(unlocked));

  // R8
  violation_only_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    accViolation |-> (accValid && !unlocked && !accEnable));

  // R9
  grant_when_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && accValid) |-> (accEnable && !accViolation));

  // R10
  quiet_without_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!accEnable && !accViolation));

endmodule

bind magicSeqUnlocker unlockChk #(.LAST_KEY(KEY_SEQ[NUM_KEYS-1])) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .keyWrEn      (keyWrEn),
  .keyWrData    (keyWrData),
  .accValid     (accValid),
  .unlocked     (unlocked),
  .accEnable    (accEnable),
  .accViolation (accViolation)
);

// File: tb/magicSeqUnlocker_tb.sv
module magicSeqUnlocker_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] K0 = 32'h3A7F5CA3;
  localparam logic [31:0] K1 = 32'hA1E34F20;
  localparam logic [31:0] K2 = 32'h9608B2C1;
  localparam logic [31:0] LOCKW = 32'hDEADBEEF;
  localparam logic [31:0] BASE = 32'h0004_0000;
  localparam logic [31:0] SIZE = 32'h0000_2000;
  localparam logic [31:0] ENDA = BASE + 2 * SIZE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        keyWrEn = 1'b0;
  logic [31:0] keyWrData = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        unlocked, accEnable, accViolation;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  magicSeqUnlocker #(.REGION_BASE(BASE), .BLOCK_SIZE(SIZE)) u_dut (
    .clk(clk), .rstN(rstN), .keyWrEn(keyWrEn), .keyWrData(keyWrData),
    .accValid(accValid), .accAddr(accAddr), .unlocked(unlocked),
    .accEnable(accEnable), .accViolation(accViolation)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one captured write; returns just after the following falling edge
  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    keyWrEn = 1'b1;
    keyWrData = w;
    @(negedge clk);
    keyWrEn = 1'b0;
    keyWrData = 32'h5555_AAAA;
    #1;
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic v,
                       input logic expEn, input logic expViol);
    @(negedge clk);
    accValid = v;
    accAddr = a;
    #1;
    chk({req, " enable"}, 32'(accEnable), 32'(expEn));
    chk({req, " violation"}, 32'(accViolation), 32'(expViol));
    accValid = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 unlocked after reset", 32'(unlocked), 32'h0);
    probe("R8 locked in-window", BASE + 32'h10, 1'b1, 1'b0, 1'b1);
    wr(K1); wr(K2);
    chk("R1 tracker idle after reset", 32'(unlocked), 32'h0);
  endtask

  task automatic tUnlock();
    wr(32'h1234);
    wr(K0); chk("R2 after word one", 32'(unlocked), 32'h0);
    wr(K1); chk("R2 after word two", 32'(unlocked), 32'h0);
    wr(K2); chk("R2 after word three", 32'(unlocked), 32'h1);
    probe("R9 unlocked in-window", BASE + 32'h40, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic tRelock();
    wr(LOCKW); chk("R3 lock word", 32'(unlocked), 32'h0);
    wr(K0); wr(K1); wr(K2);
    chk("R3 reopen", 32'(unlocked), 32'h1);
    wr(32'h1234); chk("R3 other word", 32'(unlocked), 32'h0);
  endtask

  task automatic tMidWrong();
    wr(K0); wr(32'h0000_0055); wr(K1); wr(K2);
    chk("R4 wrong mid word discards", 32'(unlocked), 32'h0);
    wr(K0); wr(K1); wr(LOCKW); wr(K2);
    chk("R4 wrong before last", 32'(unlocked), 32'h0);
    wr(K0); wr(K1); wr(K2);
    chk("R4 full sequence after restart", 32'(unlocked), 32'h1);
    wr(LOCKW);
  endtask

  task automatic tRepeatFirst();
    wr(K0); wr(K0); wr(K1); wr(K2);
    chk("R5 repeated first word", 32'(unlocked), 32'h1);
    wr(LOCKW);
    wr(K0); wr(K1); wr(K0); wr(K1); wr(K2);
    chk("R5 first word after step two", 32'(unlocked), 32'h1);
    wr(LOCKW);
  endtask

  task automatic tNoStrobe();
    wr(K0);
    @(negedge clk); keyWrData = K1;
    @(negedge clk); keyWrData = K2;
    @(negedge clk); #1;
    chk("R6 no strobe no advance", 32'(unlocked), 32'h0);
    wr(K1); wr(K2);
    chk("R6 tracker held at step one", 32'(unlocked), 32'h1);
    @(negedge clk); keyWrData = LOCKW;
    @(negedge clk); keyWrData = 32'h1234;
    @(negedge clk); #1;
    chk("R6 unlocked held", 32'(unlocked), 32'h1);
  endtask

  task automatic tRestartOnFirst();
    wr(K0); chk("R11 first word relocks", 32'(unlocked), 32'h0);
    wr(K1); wr(K2);
    chk("R11 counted as step one", 32'(unlocked), 32'h1);
    wr(LOCKW);
  endtask

  task automatic tBounds();
    probe("R7 below base", BASE - 32'h1, 1'b1, 1'b1, 1'b0);
    probe("R7 at base", BASE, 1'b1, 1'b0, 1'b1);
    probe("R7 last in window", ENDA - 32'h1, 1'b1, 1'b0, 1'b1);
    probe("R7 at end", ENDA, 1'b1, 1'b1, 1'b0);
    probe("R8 far outside", 32'h0, 1'b1, 1'b1, 1'b0);
    probe("R10 no request in-window", BASE, 1'b0, 1'b0, 1'b0);
    probe("R10 no request outside", 32'h100, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    tReset();
    tUnlock();
    tRelock();
    tMidWrong();
    tRepeatFirst();
    tNoStrobe();
    tRestartOnFirst();
    tBounds();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule